// File: doc/BRIEF.md
# Fault Latch and LED Inhibit Controller

This block gathers the digital outputs of the protection comparators of a boost-powered LED driver: output over-voltage, LED-node short, die over-temperature and supply under-voltage. It also takes a die cool-down flag. It brings each flag into the clock domain and filters it. It then records the first three faults as sticky bits in an 8-bit interrupt byte. It drives one inhibit line that the LED sequencer and the boost enable both obey.

A software read of the interrupt byte produces a one-cycle clear strobe. The strobe clears every bit whose fault has gone away. A bit whose fault is still present stays set. Over-temperature keeps LED activity blocked until the die has cooled. Under-voltage has no interrupt bit. It is sampled only in the window just before the converter starts, and the sampled result also blocks LED activity.

Top module: `flt_inhibit_ctrl`

## Requirements
- R1: After reset the interrupt byte reads 00h and the inhibit output is low.
- R2: Each comparator flag passes through a two-flop synchronizer. Its filtered value changes only after the synchronized value has differed from it for 4 consecutive cycles. A raw pulse of 3 cycles has no effect. A raw level held steady sets its interrupt bit at the seventh rising edge after the first edge that samples it.
- R3: A filtered over-voltage flag sets interrupt bit 7 and raises the inhibit output.
- R4: A filtered short-circuit flag sets interrupt bit 6 only while the driver-started input is high. While that input is low, the flag is ignored.
- R5: A filtered over-temperature flag sets interrupt bit 5. After such an event the inhibit output stays high until two things are true: the filtered cool-down flag has been seen high with over-temperature absent, and bit 5 has been read-cleared. These may happen in either order.
- R6: A read-clear strobe clears, at the next edge, every interrupt bit whose fault condition is inactive.
- R7: An interrupt bit whose fault condition is active in the cycle of a read-clear strobe stays set.
- R8: While the check-window input is high and the boost-ramp input is low, the under-voltage block takes the filtered under-voltage flag. At all other times it holds its value. The block raises the inhibit output and never sets an interrupt bit.
- R9: Interrupt bits 4 to 0 always read 0.
- R10: The inhibit output is high exactly when an interrupt bit is set, the over-temperature hold is active, or the under-voltage block is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovp_raw_i | input | 1 | Output over-voltage comparator flag (asynchronous) |
| scf_raw_i | input | 1 | LED-node short comparator flag (asynchronous) |
| otp_raw_i | input | 1 | Die over-temperature flag (asynchronous) |
| cool_raw_i | input | 1 | Die back below the release temperature (asynchronous) |
| uv_raw_i | input | 1 | Supply under-voltage flag (asynchronous) |
| drv_started_i | input | 1 | Sequencer: LED driver has started |
| boost_ramp_i | input | 1 | Sequencer: boost converter is ramping up |
| uv_chk_win_i | input | 1 | Sequencer: window just before boost start |
| rd_clr_i | input | 1 | One-cycle strobe from a read of the interrupt byte |
| int_reg_o | output | 8 | Interrupt byte: bit 7 over-voltage, bit 6 short, bit 5 over-temperature |
| inhibit_o | output | 1 | Shutdown of the LED driver and boost converter |

## Verification
Two functions can fall on the same edge: a read-clear strobe and the setting of a latch. The bench holds the over-voltage flag active while it strobes a read. It then times a short-circuit flag so that its bit sets on the very edge where a read clears a stale over-voltage bit. The expected byte is worked out from the filter latency. In the first case bit 7 must survive the read. In the second the byte must read 40h.

// File: rtl/flt_pkg.sv
package flt_pkg;
  // flag slots in the filtered vector
  localparam int FLT_N    = 5;
  localparam int IDX_OVP  = 0;
  localparam int IDX_SCF  = 1;
  localparam int IDX_OTP  = 2;
  localparam int IDX_UV   = 3;
  localparam int IDX_COOL = 4;
  // sticky latch slots
  localparam int LAT_N    = 3;
  // interrupt byte layout
  localparam int INT_W    = 8;
  localparam int BIT_OVP  = 7;
  localparam int BIT_SCF  = 6;
  localparam int BIT_OTP  = 5;
endpackage

// File: rtl/flt_deglitch.sv
module flt_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stage;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   filt_q, filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign stage = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (stage != filt_q) begin
      if (cnt_q == CNT_W'(STABLE_CYC - 1)) begin
        filt_d = stage;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R2
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(stage)));
endmodule

// File: rtl/flt_sticky.sv
module flt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb q_d = set_i | (q_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !clr_i) |=> q_q);
endmodule

// File: rtl/flt_inhibit_ctrl.sv
module flt_inhibit_ctrl
  import flt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovp_raw_i,
  input  logic             scf_raw_i,
  input  logic             otp_raw_i,
  input  logic             cool_raw_i,
  input  logic             uv_raw_i,
  input  logic             drv_started_i,
  input  logic             boost_ramp_i,
  input  logic             uv_chk_win_i,
  input  logic             rd_clr_i,
  output logic [INT_W-1:0] int_reg_o,
  output logic             inhibit_o
);
  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[RST_STAGES-1];

  // flag filtering
  logic [FLT_N-1:0] raw_vec, flt_vec;
  assign raw_vec[IDX_OVP]  = ovp_raw_i;
  assign raw_vec[IDX_SCF]  = scf_raw_i;
  assign raw_vec[IDX_OTP]  = otp_raw_i;
  assign raw_vec[IDX_UV]   = uv_raw_i;
  assign raw_vec[IDX_COOL] = cool_raw_i;

  for (genvar g = 0; g < FLT_N; g++) begin : g_filt
    flt_deglitch #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_filt (
      .clk(clk), .rst_n(rst_q), .raw_i(raw_vec[g]), .filt_o(flt_vec[g]));
  end

  // sticky interrupt latches, slot 0 ovp, 1 scf, 2 otp
  logic [LAT_N-1:0] lat_set, lat_q;
  assign lat_set[0] = flt_vec[IDX_OVP];
  assign lat_set[1] = flt_vec[IDX_SCF] & drv_started_i;
  assign lat_set[2] = flt_vec[IDX_OTP];

  for (genvar g = 0; g < LAT_N; g++) begin : g_lat
    flt_sticky u_lat (
      .clk(clk), .rst_n(rst_q), .set_i(lat_set[g]), .clr_i(rd_clr_i), .q_o(lat_q[g]));
  end

  // over-temperature hold and under-voltage block
  logic otp_hold_q, otp_hold_d;
  logic uv_blk_q, uv_blk_d;
  logic uv_sample_en;

  assign uv_sample_en = uv_chk_win_i & ~boost_ramp_i;

  always_comb begin
    otp_hold_d = otp_hold_q;
    if (flt_vec[IDX_OTP])       otp_hold_d = 1'b1;
    else if (flt_vec[IDX_COOL]) otp_hold_d = 1'b0;
    uv_blk_d = uv_blk_q;
    if (uv_sample_en) uv_blk_d = flt_vec[IDX_UV];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      otp_hold_q <= 1'b0;
      uv_blk_q   <= 1'b0;
    end else begin
      otp_hold_q <= otp_hold_d;
      uv_blk_q   <= uv_blk_d;
    end
  end

  always_comb begin
    int_reg_o          = '0;
    int_reg_o[BIT_OVP] = lat_q[0];
    int_reg_o[BIT_SCF] = lat_q[1];
    int_reg_o[BIT_OTP] = lat_q[2];
  end

  assign inhibit_o = (|lat_q) | otp_hold_q | uv_blk_q;

  // R4
  scf_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(int_reg_o[BIT_SCF]) |-> $past(drv_started_i));
  // R5
  otp_release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(otp_hold_q) |-> ($past(flt_vec[IDX_COOL]) && !$past(flt_vec[IDX_OTP])));
  // R8
  uv_boost_ignore_chk: assert property (@(posedge clk) disable iff (!rst_q)
    boost_ramp_i |=> $stable(uv_blk_q));
  // R5
  otp_bit_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    int_reg_o[BIT_OTP] |-> inhibit_o);
endmodule

// File: tb/flt_inhibit_ctrl_tb.sv
module flt_inhibit_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ovp, scf, otp, cool, uv, drv, boost, win, rd;
  logic [7:0] ireg;
  logic       inh;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  flt_inhibit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .ovp_raw_i(ovp), .scf_raw_i(scf), .otp_raw_i(otp), .cool_raw_i(cool), .uv_raw_i(uv),
    .drv_started_i(drv), .boost_ramp_i(boost), .uv_chk_win_i(win), .rd_clr_i(rd),
    .int_reg_o(ireg), .inhibit_o(inh));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    wait_cyc(1);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int", ireg, 8'h00);
    chk("R1 inh", {7'd0, inh}, 8'h00);
  endtask

  task automatic t_filter();
    ovp = 1'b1; wait_cyc(3); ovp = 1'b0;
    wait_cyc(12);
    chk("R2 3-cycle pulse ignored", ireg, 8'h00);
    ovp = 1'b1;
    wait_cyc(6);
    chk("R2 not yet set", ireg, 8'h00);
    wait_cyc(1);
    chk("R2 R3 set on seventh edge", ireg, 8'h80);
    chk("R3 R10 inhibit", {7'd0, inh}, 8'h01);
    chk("R9 low bits zero", {3'd0, ireg[4:0]}, 8'h00);
  endtask

  task automatic t_clear_vs_active();
    pulse_rd();
    chk("R7 active fault survives read", ireg, 8'h80);
    ovp = 1'b0;
    wait_cyc(10);
    chk("R6 sticky without read", ireg, 8'h80);
    scf = 1'b1; drv = 1'b1;
    wait_cyc(6);
    rd = 1'b1;
    wait_cyc(1);
    rd = 1'b0;
    chk("R6 R7 clear and set same edge", ireg, 8'h40);
    scf = 1'b0;
    wait_cyc(10);
    pulse_rd();
    chk("R6 read clears scf", ireg, 8'h00);
    chk("R10 inhibit drops", {7'd0, inh}, 8'h00);
    drv = 1'b0;
  endtask

  task automatic t_scf_gate();
    scf = 1'b1;
    wait_cyc(12);
    chk("R4 ignored when driver idle", ireg, 8'h00);
    drv = 1'b1;
    wait_cyc(1);
    chk("R4 set once driver started", ireg, 8'h40);
    drv = 1'b0; scf = 1'b0;
    wait_cyc(10);
    pulse_rd();
    chk("R4 cleared", ireg, 8'h00);
  endtask

  task automatic t_otp();
    otp = 1'b1; wait_cyc(8); otp = 1'b0;
    wait_cyc(8);
    chk("R5 otp bit", ireg, 8'h20);
    pulse_rd();
    chk("R5 bit read-cleared", ireg, 8'h00);
    chk("R5 still hot keeps inhibit", {7'd0, inh}, 8'h01);
    cool = 1'b1;
    wait_cyc(10);
    chk("R5 cooled and read releases", {7'd0, inh}, 8'h00);
    cool = 1'b0;
    wait_cyc(10);
    otp = 1'b1; wait_cyc(8); otp = 1'b0;
    wait_cyc(8);
    cool = 1'b1;
    wait_cyc(10);
    chk("R5 cooled but unread keeps inhibit", {7'd0, inh}, 8'h01);
    pulse_rd();
    chk("R5 read after cool releases", {7'd0, inh}, 8'h00);
    cool = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_uv();
    uv = 1'b1; win = 1'b1;
    wait_cyc(10);
    chk("R8 uv blocks", {7'd0, inh}, 8'h01);
    chk("R8 uv no interrupt", ireg, 8'h00);
    win = 1'b0; uv = 1'b0;
    wait_cyc(10);
    chk("R8 held outside window", {7'd0, inh}, 8'h01);
    win = 1'b1;
    wait_cyc(2);
    chk("R8 released in window", {7'd0, inh}, 8'h00);
    boost = 1'b1; uv = 1'b1;
    wait_cyc(10);
    chk("R8 ignored during boost", {7'd0, inh}, 8'h00);
    boost = 1'b0; win = 1'b0; uv = 1'b0;
    wait_cyc(10);
    chk("R8 R9 byte still clear", ireg, 8'h00);
  endtask

  initial begin
    ovp = 0; scf = 0; otp = 0; cool = 0; uv = 0;
    drv = 0; boost = 0; win = 0; rd = 0;
    rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_filter();
    t_clear_vs_active();
    t_scf_gate();
    t_otp();
    t_uv();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule